// File: doc/BRIEF.md
# Indexed Block Register Target on a Two-Wire Management Bus

This block is a target on an SMBus-style two-wire bus that holds the small control register file of a clock fan-out buffer. A host writes a run of registers by giving a start index and an explicit byte count, then the data bytes. To read, the host sets the index in a write, issues a repeated START and the read address. The target then returns a byte count taken from a writable length register, followed by that many register bytes. The index advances after every byte and wraps at the end of the register file.

The bus clock and data line are sampled on a free-running system clock through a two-flop synchronizer. Line events (START, STOP, clock edges) are found from the synchronized levels. The data line is bidirectional, so the block sees it as an input and drives a pull-low enable for an open-drain pad. The register values leave the block as plain control outputs for the clock output logic: a mode byte, per-output enables, per-output stop-obey bits, a device identifier and the read length. There is no stream interface, so every port is a plain level.

Top module: `smbr_ctrl_regs`

## Requirements
- R1: After reset, mode_cfg = 0x07, out_en = 0xFF, stop_en = 0x00, dev_id = 0x83 and rd_len = 0x07. mode_cfg is register 0: bit 7 = power-down tristate, bit 6 = stop tristate, bit 2 = low bandwidth, bit 1 = PLL mode, bit 0 = full rate. out_en is register 1, stop_en is register 2, dev_id is register 5 and rd_len is register 6.
- R2: The target acknowledges, by pulling SDA low in the ninth clock, only the address bytes 0xDC (write) and 0xDD (read). After any other address byte it keeps SDA released and changes no register until the next START.
- R3: A write transaction (START, 0xDC, index N, count X, data) stores data byte k in register (N mod 8 + k) mod 8, so register 7 is followed by register 0. The target acknowledges the address, index, count and each stored byte. The register outputs show the new values after the transaction.
- R4: Data bytes beyond the count X are not acknowledged and not stored. With X = 0, no data byte is stored.
- R5: Bits 5:3 of register 0 and all of registers 3 and 7 ignore writes and read as 0. Register 4 ignores writes and reads {REV_ID, 4'b0001}, with REV_ID = 3 by default.
- R6: A read transaction (START, 0xDC, index N, repeated START, 0xDD) returns first the value of register 6 (X), then registers N, N+1, ... with the same wrap as writes. The host acknowledges each byte except the last.
- R7: When more than X data bytes are read, every byte after the X-th reads 0xFF.
- R8: When the host does not acknowledge a read byte, the target releases SDA and stays silent until the next START, so any further bytes read 0xFF.
- R9: A STOP or START in the middle of a transaction ends it. Bytes already acknowledged stay stored, and a partly sent byte is dropped.
- R10: The SDA pull-low output changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_pull | output | 1 | Pull data line low (open-drain enable) |
| mode_cfg | output | 8 | Register 0: drive modes, bandwidth, PLL/bypass, divider |
| out_en | output | 8 | Register 1: per-output enables |
| stop_en | output | 8 | Register 2: per-output obey-stop bits |
| dev_id | output | 8 | Register 5: device identifier |
| rd_len | output | 8 | Register 6: number of bytes a block read returns |

## Verification
The assertions assume a well-behaved host. SCL edges are spaced by many system clocks, so every edge passes the synchronizer before the next one. The host changes SDA only while SCL is low, except when it forms a START or STOP, and it never forms a START or STOP while the target is pulling the line. The bench's host drives the bus with a quarter-bit time of six system clocks. It always releases SDA before raising SCL in any slot where the target may drive, and it frames each START and STOP with the line released. Its random index, count and data values all stay inside these timing rules.

// File: rtl/smbr_pkg.sv
package smbr_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ADDR,
    PH_INDEX,
    PH_COUNT,
    PH_WDATA,
    PH_READ
  } phase_t;

  localparam int SLOT_MODE = 0;
  localparam int SLOT_OE   = 1;
  localparam int SLOT_STOP = 2;
  localparam int SLOT_ID   = 4;
  localparam int SLOT_DEV  = 5;
  localparam int SLOT_LEN  = 6;

  localparam logic [3:0] VENDOR_NIBBLE = 4'b0001;

  function automatic logic [7:0] reg_reset_val(int unsigned slot);
    case (slot)
      0:       return 8'h07;
      1:       return 8'hFF;
      5:       return 8'h83;
      6:       return 8'h07;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] reg_write_mask(int unsigned slot);
    case (slot)
      0:             return 8'hC7;
      1, 2, 5, 6:    return 8'hFF;
      default:       return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/smbr_sync.sv
module smbr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic bus_start,
  output logic bus_stop
);

  logic [STAGES:0] scl_pipe;
  logic [STAGES:0] sda_pipe;
  logic            scl_prev;
  logic            sda_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-1:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-1:0], sda_i};
    end
  end

  assign scl_lvl  = scl_pipe[STAGES-1];
  assign sda_lvl  = sda_pipe[STAGES-1];
  assign scl_prev = scl_pipe[STAGES];
  assign sda_prev = sda_pipe[STAGES];

  assign scl_rise  = scl_lvl & ~scl_prev;
  assign scl_fall  = ~scl_lvl & scl_prev;
  assign bus_start = scl_lvl & scl_prev & sda_prev & ~sda_lvl;
  assign bus_stop  = scl_lvl & scl_prev & ~sda_prev & sda_lvl;

endmodule

// File: rtl/smbr_regfile.sv
module smbr_regfile
  import smbr_pkg::*;
#(
  parameter int         REG_COUNT = 8,
  parameter logic [3:0] REV_ID    = 4'h3,
  localparam int        IW        = $clog2(REG_COUNT)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [IW-1:0]          wr_idx,
  input  logic [7:0]             wr_data,
  input  logic [IW-1:0]          rd_idx,
  output logic [7:0]             rd_data,
  output logic [REG_COUNT*8-1:0] regs_flat,
  output logic [REG_COUNT-1:0]   we_vec
);

  for (genvar g = 0; g < REG_COUNT; g++) begin : g_reg
    localparam logic [7:0] RST = reg_reset_val(g);
    localparam logic [7:0] MSK = reg_write_mask(g);
    logic [7:0] q;

    assign we_vec[g] = wr_en && (wr_idx == IW'(g));

    if (MSK == 8'h00) begin : g_fixed
      assign q = RST;
    end else begin : g_store
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         q <= RST;
        else if (we_vec[g]) q <= (q & ~MSK) | (wr_data & MSK);
      end
    end

    if (g == SLOT_ID) begin : g_ident
      assign regs_flat[g*8 +: 8] = {REV_ID, VENDOR_NIBBLE};
    end else begin : g_plain
      assign regs_flat[g*8 +: 8] = q;
    end
  end

  assign rd_data = regs_flat[rd_idx*8 +: 8];

endmodule

// File: rtl/smbr_engine.sv
module smbr_engine
  import smbr_pkg::*;
#(
  parameter int         REG_COUNT = 8,
  parameter logic [7:0] WR_ADDR   = 8'hDC,
  parameter logic [7:0] RD_ADDR   = 8'hDD,
  localparam int        IW        = $clog2(REG_COUNT)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          sda_lvl,
  input  logic          bus_start,
  input  logic          bus_stop,
  input  logic [7:0]    rd_data,
  input  logic [7:0]    rd_len,
  output logic [IW-1:0] rd_idx,
  output logic [IW-1:0] wr_idx,
  output logic          wr_en,
  output logic [7:0]    wr_data,
  output logic          sda_pull
);

  phase_t        phase, next_ph;
  logic [3:0]    bitcnt;
  logic [7:0]    shreg;
  logic [7:0]    remain;
  logic [7:0]    tx_next;
  logic [IW-1:0] idx_q;
  logic          in_ack, go_on, cnt_pending;
  logic          ack_byte, store_byte;

  function automatic logic [IW-1:0] idx_step(logic [IW-1:0] i);
    return (32'(i) == REG_COUNT - 1) ? '0 : i + 1'b1;
  endfunction

  // What to do with a fully received byte
  always_comb begin
    ack_byte   = 1'b0;
    store_byte = 1'b0;
    next_ph    = PH_IDLE;
    case (phase)
      PH_ADDR: begin
        if (shreg == WR_ADDR) begin
          ack_byte = 1'b1;
          next_ph  = PH_INDEX;
        end else if (shreg == RD_ADDR) begin
          ack_byte = 1'b1;
          next_ph  = PH_READ;
        end
      end
      PH_INDEX: begin
        ack_byte = 1'b1;
        next_ph  = PH_COUNT;
      end
      PH_COUNT: begin
        ack_byte = 1'b1;
        next_ph  = PH_WDATA;
      end
      PH_WDATA: begin
        next_ph    = PH_WDATA;
        ack_byte   = (remain != 8'd0);
        store_byte = (remain != 8'd0);
      end
      default: ;
    endcase
  end

  // Next byte to shift out on a read
  always_comb begin
    if (cnt_pending)          tx_next = rd_len;
    else if (remain != 8'd0)  tx_next = rd_data;
    else                      tx_next = 8'hFF;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase       <= PH_IDLE;
      bitcnt      <= '0;
      shreg       <= '0;
      remain      <= '0;
      idx_q       <= '0;
      in_ack      <= 1'b0;
      go_on       <= 1'b0;
      cnt_pending <= 1'b0;
      wr_en       <= 1'b0;
      wr_idx      <= '0;
      wr_data     <= '0;
      sda_pull    <= 1'b0;
    end else begin
      wr_en <= 1'b0;
      if (bus_start) begin
        phase       <= PH_ADDR;
        bitcnt      <= '0;
        in_ack      <= 1'b0;
        cnt_pending <= 1'b0;
        sda_pull    <= 1'b0;
      end else if (bus_stop) begin
        phase    <= PH_IDLE;
        bitcnt   <= '0;
        in_ack   <= 1'b0;
        sda_pull <= 1'b0;
      end else if (scl_fall && in_ack) begin
        // end of an acknowledge slot
        in_ack <= 1'b0;
        bitcnt <= '0;
        if (phase == PH_READ && go_on) begin
          shreg    <= tx_next;
          sda_pull <= ~tx_next[7];
          if (cnt_pending) begin
            cnt_pending <= 1'b0;
            remain      <= rd_len;
          end else if (remain != 8'd0) begin
            remain <= remain - 8'd1;
            idx_q  <= idx_step(idx_q);
          end
        end else begin
          sda_pull <= 1'b0;
          if (phase == PH_READ) phase <= PH_IDLE;
        end
      end else if (phase == PH_READ) begin
        if (scl_rise) begin
          if (bitcnt == 4'd8) go_on  <= ~sda_lvl;
          else                bitcnt <= bitcnt + 4'd1;
        end else if (scl_fall) begin
          if (bitcnt == 4'd8) begin
            sda_pull <= 1'b0;
            in_ack   <= 1'b1;
          end else begin
            shreg    <= {shreg[6:0], 1'b1};
            sda_pull <= ~shreg[6];
          end
        end
      end else if (phase != PH_IDLE) begin
        if (scl_rise && bitcnt != 4'd8) begin
          shreg  <= {shreg[6:0], sda_lvl};
          bitcnt <= bitcnt + 4'd1;
        end else if (scl_fall && bitcnt == 4'd8) begin
          in_ack   <= 1'b1;
          sda_pull <= ack_byte;
          phase    <= next_ph;
          if (phase == PH_ADDR && next_ph == PH_READ) cnt_pending <= 1'b1;
          if (phase == PH_INDEX) idx_q <= IW'(32'(shreg) % REG_COUNT);
          if (phase == PH_COUNT) remain <= shreg;
          if (store_byte) begin
            wr_en   <= 1'b1;
            wr_idx  <= idx_q;
            wr_data <= shreg;
            idx_q   <= idx_step(idx_q);
            remain  <= remain - 8'd1;
          end
        end
      end
    end
  end

  assign rd_idx = idx_q;

endmodule

// File: rtl/smbr_ctrl_regs.sv
module smbr_ctrl_regs
  import smbr_pkg::*;
#(
  parameter int         REG_COUNT   = 8,
  parameter logic [7:0] WR_ADDR     = 8'hDC,
  parameter logic [7:0] RD_ADDR     = 8'hDD,
  parameter logic [3:0] REV_ID      = 4'h3,
  parameter int         SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_pull,
  output logic [7:0] mode_cfg,
  output logic [7:0] out_en,
  output logic [7:0] stop_en,
  output logic [7:0] dev_id,
  output logic [7:0] rd_len
);

  localparam int IW = $clog2(REG_COUNT);

  logic                   scl_lvl, sda_lvl, scl_rise, scl_fall, bus_start, bus_stop;
  logic                   wr_en;
  logic [IW-1:0]          wr_idx, rd_idx;
  logic [7:0]             wr_data, rd_data;
  logic [REG_COUNT*8-1:0] regs_flat;
  logic [REG_COUNT-1:0]   we_vec;

  smbr_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_lvl   (scl_lvl),
    .sda_lvl   (sda_lvl),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .bus_start (bus_start),
    .bus_stop  (bus_stop)
  );

  smbr_engine #(
    .REG_COUNT (REG_COUNT),
    .WR_ADDR   (WR_ADDR),
    .RD_ADDR   (RD_ADDR)
  ) u_engine (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .sda_lvl   (sda_lvl),
    .bus_start (bus_start),
    .bus_stop  (bus_stop),
    .rd_data   (rd_data),
    .rd_len    (rd_len),
    .rd_idx    (rd_idx),
    .wr_idx    (wr_idx),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .sda_pull  (sda_pull)
  );

  smbr_regfile #(
    .REG_COUNT (REG_COUNT),
    .REV_ID    (REV_ID)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .wr_data   (wr_data),
    .rd_idx    (rd_idx),
    .rd_data   (rd_data),
    .regs_flat (regs_flat),
    .we_vec    (we_vec)
  );

  assign mode_cfg = regs_flat[SLOT_MODE*8 +: 8];
  assign out_en   = regs_flat[SLOT_OE*8   +: 8];
  assign stop_en  = regs_flat[SLOT_STOP*8 +: 8];
  assign dev_id   = regs_flat[SLOT_DEV*8  +: 8];
  assign rd_len   = regs_flat[SLOT_LEN*8  +: 8];

endmodule

// File: rtl/smbr_ctrl_regs_chk.sv
module smbr_ctrl_regs_chk #(
  parameter int REG_COUNT = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 sda_pull,
  input logic                 scl_lvl,
  input logic                 wr_en,
  input logic [REG_COUNT-1:0] we_vec,
  input logic [7:0]           mode_cfg,
  input logic [7:0]           out_en,
  input logic [7:0]           stop_en,
  input logic [7:0]           dev_id,
  input logic [7:0]           rd_len
);

  // R1
  reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> (mode_cfg == 8'h07 && out_en == 8'hFF && stop_en == 8'h00 &&
                       dev_id == 8'h83 && rd_len == 8'h07));

  // R10
  sda_low_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_pull != $past(sda_pull)) |-> !$past(scl_lvl));

  // R3
  single_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(we_vec));

  // R3
  write_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en);

  // R2
  reg_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ({mode_cfg, out_en, stop_en, dev_id, rd_len} !=
     $past({mode_cfg, out_en, stop_en, dev_id, rd_len})) |-> $past(wr_en));

endmodule

bind smbr_ctrl_regs smbr_ctrl_regs_chk #(.REG_COUNT(REG_COUNT)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .sda_pull (sda_pull),
  .scl_lvl  (scl_lvl),
  .wr_en    (wr_en),
  .we_vec   (we_vec),
  .mode_cfg (mode_cfg),
  .out_en   (out_en),
  .stop_en  (stop_en),
  .dev_id   (dev_id),
  .rd_len   (rd_len)
);

// File: tb/smbr_ctrl_regs_test.sv
module smbr_ctrl_regs_test;
  localparam int         Q     = 6;
  localparam logic [3:0] REV   = 4'h3;
  localparam int         LIMIT = 190000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic hpull = 1'b0;
  logic done = 1'b0;
  wire  uut_pull;
  wire  sda_line;
  logic [7:0] mode_cfg, out_en, stop_en, dev_id, rd_len;

  assign sda_line = ~(hpull | uut_pull);

  always #10 clk = ~clk;

  smbr_ctrl_regs uut (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl),
    .sda_i    (sda_line),
    .sda_pull (uut_pull),
    .mode_cfg (mode_cfg),
    .out_en   (out_en),
    .stop_en  (stop_en),
    .dev_id   (dev_id),
    .rd_len   (rd_len)
  );

  int checks = 0;
  int errors = 0;
  logic [7:0] model [8];
  logic [7:0] wdat  [16];

  function automatic logic [7:0] wmask(int i);
    case (i)
      0:          return 8'hC7;
      1, 2, 5, 6: return 8'hFF;
      default:    return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] expect_rd(int i);
    return (i == 4) ? {REV, 4'b0001} : model[i];
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    hpull = 1'b0; tick(Q);
    scl = 1'b1;   tick(Q);
    hpull = 1'b1; tick(Q);
    scl = 1'b0;   tick(Q);
  endtask

  task automatic bus_stop();
    hpull = 1'b1; tick(Q);
    scl = 1'b1;   tick(Q);
    hpull = 1'b0; tick(Q);
  endtask

  task automatic send_bit(logic b);
    hpull = ~b; tick(Q);
    scl = 1'b1; tick(2*Q);
    scl = 1'b0; tick(Q);
  endtask

  task automatic recv_bit(output logic b);
    logic late;
    hpull = 1'b0; tick(Q);
    scl = 1'b1;   tick(2);
    b = sda_line; tick(2*Q - 3);
    late = sda_line;
    chk("R10 data stable while clock high", late, b);
    tick(1);
    scl = 1'b0;   tick(Q);
  endtask

  task automatic send_byte(logic [7:0] d, output logic acked);
    logic b;
    for (int i = 7; i >= 0; i--) send_bit(d[i]);
    recv_bit(b);
    acked = ~b;
  endtask

  task automatic recv_byte(output logic [7:0] d, input logic host_ack);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      recv_bit(b);
      d[i] = b;
    end
    send_bit(~host_ack);
  endtask

  task automatic model_write(int i, logic [7:0] d);
    model[i] = (model[i] & ~wmask(i)) | (d & wmask(i));
  endtask

  task automatic check_outs(string req);
    chk({req, " mode_cfg"}, mode_cfg, model[0]);
    chk({req, " out_en"},   out_en,   model[1]);
    chk({req, " stop_en"},  stop_en,  model[2]);
    chk({req, " dev_id"},   dev_id,   model[5]);
    chk({req, " rd_len"},   rd_len,   model[6]);
  endtask

  // write transaction; data from wdat
  task automatic wr_txn(logic [7:0] idx, logic [7:0] cnt, int nsend, string req);
    logic a;
    bus_start();
    send_byte(8'hDC, a); chk({req, " addr ack"}, a, 1'b1);
    send_byte(idx, a);   chk({req, " index ack"}, a, 1'b1);
    send_byte(cnt, a);   chk({req, " count ack"}, a, 1'b1);
    for (int i = 0; i < nsend; i++) begin
      send_byte(wdat[i], a);
      if (i < int'(cnt)) begin
        chk({req, " data ack"}, a, 1'b1);
        model_write((int'(idx) % 8 + i) % 8, wdat[i]);
      end else begin
        chk("R4 excess byte nack", a, 1'b0);
      end
    end
    bus_stop();
  endtask

  // read transaction: count byte plus nread bytes
  task automatic rd_txn(int idx, int nread, string req);
    logic       a;
    logic [7:0] d;
    bus_start();
    send_byte(8'hDC, a);      chk({req, " wr addr ack"}, a, 1'b1);
    send_byte(8'(idx), a);    chk({req, " index ack"}, a, 1'b1);
    bus_start();
    send_byte(8'hDD, a);      chk({req, " rd addr ack"}, a, 1'b1);
    recv_byte(d, nread > 0);  chk({req, " count byte"}, d, model[6]);
    for (int i = 0; i < nread; i++) begin
      recv_byte(d, i < nread - 1);
      if (i < int'(model[6])) chk({req, " data byte"}, d, expect_rd((idx + i) % 8));
      else                    chk("R7 byte past count", d, 8'hFF);
    end
    bus_stop();
  endtask

  initial begin
    repeat (LIMIT) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected=<%0d cycles", LIMIT, LIMIT);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic       a;
    logic [7:0] d;
    void'($urandom(32'h5EED));
    for (int i = 0; i < 8; i++) model[i] = 8'h00;
    model[0] = 8'h07; model[1] = 8'hFF; model[5] = 8'h83; model[6] = 8'h07;

    tick(5);
    rst_n = 1'b1;
    tick(5);
    // R1 reset state
    check_outs("R1 reset");
    chk("R1 sda released", uut_pull, 1'b0);

    // R3 basic write to registers 1 and 2
    wdat[0] = 8'hA5; wdat[1] = 8'h3C;
    wr_txn(8'd1, 8'd2, 2, "R3 write");
    check_outs("R3 after write");

    // R3 wrap 6->7->0 and R5 masks on register 0 and 7
    wdat[0] = 8'h08; wdat[1] = 8'h55; wdat[2] = 8'hFF;
    wr_txn(8'd6, 8'd3, 3, "R3 wrap");
    check_outs("R3 wrap");
    chk("R5 reserved mode bits", mode_cfg, 8'hC7);

    // R5 writes to registers 3 and 4 ignored; index byte taken modulo 8 (11 -> 3)
    wdat[0] = 8'hEE; wdat[1] = 8'h77;
    wr_txn(8'd11, 8'd2, 2, "R5 read-only");
    rd_txn(0, 8, "R6 full read");
    chk("R5 id register", expect_rd(4), {REV, 4'b0001});

    // R4 count of one, three bytes sent; then count zero
    wdat[0] = 8'h5A; wdat[1] = 8'h11; wdat[2] = 8'h22;
    wr_txn(8'd5, 8'd1, 3, "R4 excess");
    check_outs("R4 excess");
    wdat[0] = 8'h00;
    wr_txn(8'd1, 8'd0, 1, "R4 zero count");
    check_outs("R4 zero count");

    // R2 foreign addresses
    bus_start();
    send_byte(8'hA0, a); chk("R2 foreign addr nack", a, 1'b0);
    send_byte(8'h01, a); chk("R2 ignored index", a, 1'b0);
    send_byte(8'h01, a); chk("R2 ignored count", a, 1'b0);
    send_byte(8'h00, a); chk("R2 ignored data", a, 1'b0);
    bus_stop();
    check_outs("R2 no change");
    bus_start();
    send_byte(8'hDE, a); chk("R2 near read addr nack", a, 1'b0);
    recv_byte(d, 1'b0);  chk("R2 bus released", d, 8'hFF);
    bus_stop();

    // R7 shorter read length
    wdat[0] = 8'h03;
    wr_txn(8'd6, 8'd1, 1, "R7 set length");
    rd_txn(2, 5, "R7 short");

    // R8 host nack ends read
    bus_start();
    send_byte(8'hDC, a); chk("R8 addr ack", a, 1'b1);
    send_byte(8'h00, a); chk("R8 index ack", a, 1'b1);
    bus_start();
    send_byte(8'hDD, a); chk("R8 rd addr ack", a, 1'b1);
    recv_byte(d, 1'b0);  chk("R8 count byte", d, model[6]);
    recv_byte(d, 1'b0);  chk("R8 silent after nack", d, 8'hFF);
    bus_stop();

    // R9 abort mid-byte
    bus_start();
    send_byte(8'hDC, a); chk("R9 addr ack", a, 1'b1);
    send_byte(8'h01, a); chk("R9 index ack", a, 1'b1);
    send_byte(8'h02, a); chk("R9 count ack", a, 1'b1);
    send_byte(8'h11, a); chk("R9 first data ack", a, 1'b1);
    model_write(1, 8'h11);
    for (int i = 0; i < 4; i++) send_bit(1'b0);
    bus_stop();
    check_outs("R9 after abort");
    // R9 restart ends a pending write
    bus_start();
    send_byte(8'hDC, a); chk("R9 addr ack 2", a, 1'b1);
    send_byte(8'h02, a); chk("R9 index ack 2", a, 1'b1);
    bus_start();
    send_byte(8'h40, a); chk("R9 restart foreign nack", a, 1'b0);
    bus_stop();
    check_outs("R9 after restart");

    // constrained random write/read pairs
    for (int it = 0; it < 12; it++) begin
      logic [7:0] ri, rc;
      int ns;
      ri = 8'($urandom_range(0, 15));
      rc = 8'($urandom_range(0, 9));
      ns = int'(rc) + int'($urandom_range(0, 1));
      for (int k = 0; k < 16; k++) wdat[k] = 8'($urandom);
      wr_txn(ri, rc, ns, "R3 random write");
      check_outs("R3 random");
      rd_txn(int'($urandom_range(0, 7)), 9, "R6 random read");
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule